// File: doc/BRIEF.md
# Fly-By DMA Transfer Controller

This block moves a block of data between a peripheral and memory without the CPU touching each unit. The CPU first writes a memory address, a byte count and a control word. Once the selected peripheral says its data is ready, the controller asks for the system bus. For every unit it drives the memory address and a transfer request to the peripheral. The peripheral then performs the memory access itself, which is why this style is called fly-by, and answers with an acknowledge. The controller never holds any data.

After each acknowledge the controller advances the address and lowers the remaining count. It hands the bus back after a programmable number of units, then asks for it again. When the count runs out it raises an interrupt. If an acknowledge never arrives, a watchdog aborts the transfer and flags an error. The CPU clears the interrupt through the status register.

Top module: `dma_flyby_ctrl`

## Requirements
- R1: After reset, bus_req, xfer_req and irq are low, and all four registers read as zero.
- R2: reg_sel selects the register: 0 is the memory address, 1 is the remaining byte count, 2 is control and 3 is status. Status holds bit0 busy, bit1 done and bit2 error. Address and count read back their live values while a transfer runs.
- R3: Writing control with bit0 set while idle arms a transfer and sets busy. No bus request is made while dev_ready is low.
- R4: xfer_req rises only after bus_gnt has been seen, and it stays high for the current unit until dev_ack.
- R5: For each unit, bus_addr carries the current address. Each acknowledge adds 1 to the address (control bit2 = 0, byte) or 4 (bit2 = 1, word). The count drops by the same step and stops at zero.
- R6: Control bits [7:4] hold the burst length minus one. After that many units plus one, bus_req drops for at least one cycle and is raised again if the count is non-zero.
- R7: When the count reaches zero, done and irq go high and busy, bus_req and xfer_req go low. A start with a zero count sets done in the same cycle as the write and makes no bus request.
- R8: If xfer_req waits 256 cycles without dev_ack, the transfer aborts and sets error, done and irq.
- R9: Writing status with bit1 set clears done, error and irq.
- R10: While busy, writes to the address, count and control registers are ignored.
- R11: Control bit1 (direction, 1 = memory to device) drives xfer_dir, control bits [11:8] drive port_sel, and bit2 drives xfer_word during the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| dev_ready | input | 1 | Peripheral has data ready |
| bus_req | output | 1 | System bus request |
| bus_gnt | input | 1 | System bus grant |
| bus_addr | output | 32 | Memory address of the current unit |
| xfer_req | output | 1 | Transfer request to the peripheral |
| xfer_dir | output | 1 | 1 = memory to device, 0 = device to memory |
| xfer_word | output | 1 | 1 = 4-byte unit, 0 = byte unit |
| port_sel | output | 4 | Selected peripheral port |
| dev_ack | input | 1 | Peripheral acknowledge for the current unit |
| irq | output | 1 | Interrupt, high while done is set |

## Verification
A wrong address or count register shows up at the very next unit: the address driven on the bus is off by the step, or the interrupt comes one unit early or late. A wrong burst counter changes how many times bus_req falls during a transfer, and that count is compared per vector. A wrong sequencer state shows up within a cycle as a request without a grant, as a request that survives an abort, or as an acknowledge-wait watchdog that fires on a cycle other than the 256th.

// File: rtl/dma_pkg.sv
// Package: shared constants and types for the fly-by DMA controller.
// Assumes a 2-bit register select and 32-bit register data.
package dma_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_REQ,
        ST_XFER,
        ST_REL
    } dma_state_e;

    localparam logic [1:0] SEL_ADDR = 2'd0;
    localparam logic [1:0] SEL_CNT  = 2'd1;
    localparam logic [1:0] SEL_CTRL = 2'd2;
    localparam logic [1:0] SEL_STAT = 2'd3;

    localparam int CTL_GO        = 0;
    localparam int CTL_DIR       = 1;
    localparam int CTL_WORD      = 2;
    localparam int CTL_BURST_LSB = 4;
    localparam int CTL_PORT_LSB  = 8;

    localparam int STS_BUSY = 0;
    localparam int STS_DONE = 1;
    localparam int STS_ERR  = 2;
endpackage

// File: rtl/dma_regs.sv
// Register file: address, count and control registers, plus the sticky
// done and error flags. Address and count advance on each unit step.
// Assumes step, fin_ok and fin_err are single-cycle pulses from the sequencer.
module dma_regs
    import dma_pkg::*;
#(
    parameter int RW      = 32,
    parameter int AW      = 32,
    parameter int CW      = 16,
    parameter int BURST_W = 4,
    parameter int PORT_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [1:0]         reg_sel,
    input  logic [RW-1:0]      reg_wdata,
    output logic [RW-1:0]      reg_rdata,
    input  logic               busy,
    input  logic               step,
    input  logic               fin_ok,
    input  logic               fin_err,
    output logic               start,
    output logic [AW-1:0]      cur_addr,
    output logic               cnt_zero,
    output logic               cnt_last,
    output logic               dir,
    output logic               word,
    output logic [BURST_W-1:0] blen_m1,
    output logic [PORT_W-1:0]  port,
    output logic               done
);
    logic          err_q;
    logic [CW-1:0] cur_cnt;
    logic [CW-1:0] step_sz;
    logic          wr_ok;
    logic [RW-1:0] ctrl_rd;
    logic [RW-1:0] stat_rd;

    // Step size and count-exhaust decode for the current unit width.
    always_comb begin
        step_sz  = word ? CW'(4) : CW'(1);
        cnt_last = (cur_cnt <= step_sz);
        cnt_zero = (cur_cnt == '0);
        wr_ok    = reg_we && !busy;
        start    = wr_ok && (reg_sel == SEL_CTRL) && reg_wdata[CTL_GO];
    end

    // Address register: CPU load when idle, advance on each unit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cur_addr <= '0;
        else if (step)
            cur_addr <= cur_addr + (word ? AW'(4) : AW'(1));
        else if (wr_ok && reg_sel == SEL_ADDR)
            cur_addr <= reg_wdata[AW-1:0];
    end

    // Count register: CPU load when idle, saturating decrement per unit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cur_cnt <= '0;
        else if (step)
            cur_cnt <= cnt_last ? '0 : cur_cnt - step_sz;
        else if (wr_ok && reg_sel == SEL_CNT)
            cur_cnt <= reg_wdata[CW-1:0];
    end

    // Control fields: captured only on an idle control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir     <= 1'b0;
            word    <= 1'b0;
            blen_m1 <= '0;
            port    <= '0;
        end else if (wr_ok && reg_sel == SEL_CTRL) begin
            dir     <= reg_wdata[CTL_DIR];
            word    <= reg_wdata[CTL_WORD];
            blen_m1 <= reg_wdata[CTL_BURST_LSB +: BURST_W];
            port    <= reg_wdata[CTL_PORT_LSB +: PORT_W];
        end
    end

    // Sticky completion flags: set by the sequencer, cleared by start or CPU.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done  <= 1'b0;
            err_q <= 1'b0;
        end else if (fin_err) begin
            done  <= 1'b1;
            err_q <= 1'b1;
        end else if (fin_ok) begin
            done  <= 1'b1;
        end else if (start) begin
            done  <= 1'b0;
            err_q <= 1'b0;
        end else if (reg_we && reg_sel == SEL_STAT && reg_wdata[STS_DONE]) begin
            done  <= 1'b0;
            err_q <= 1'b0;
        end
    end

    // Read-back assembly of the control and status words.
    always_comb begin
        ctrl_rd = '0;
        ctrl_rd[CTL_DIR]  = dir;
        ctrl_rd[CTL_WORD] = word;
        ctrl_rd[CTL_BURST_LSB +: BURST_W] = blen_m1;
        ctrl_rd[CTL_PORT_LSB +: PORT_W]   = port;
        stat_rd = '0;
        stat_rd[STS_BUSY] = busy;
        stat_rd[STS_DONE] = done;
        stat_rd[STS_ERR]  = err_q;
    end

    // Register read multiplexer.
    always_comb begin
        case (reg_sel)
            SEL_ADDR: reg_rdata = RW'(cur_addr);
            SEL_CNT:  reg_rdata = RW'(cur_cnt);
            SEL_CTRL: reg_rdata = ctrl_rd;
            default:  reg_rdata = stat_rd;
        endcase
    end

    AST_CTRL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_we && reg_sel == SEL_CTRL) |=> (ctrl_rd == $past(ctrl_rd))); // R10
    AST_COUNT_NONINC: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !step) |=> (cur_cnt == $past(cur_cnt))); // R10
endmodule

// File: rtl/dma_ack_watch.sv
// Acknowledge watchdog: counts the cycles a transfer request waits for the
// peripheral and flags expiry on the LIMIT-th waiting cycle.
// Assumes waiting drops for at least one cycle between units or on ack.
module dma_ack_watch #(
    parameter int LIMIT = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic waiting,
    output logic expire
);
    localparam int TW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    logic [TW-1:0] wait_cnt;

    // Wait counter: runs while waiting, clears otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wait_cnt <= '0;
        else if (waiting && !expire)
            wait_cnt <= wait_cnt + 1'b1;
        else
            wait_cnt <= '0;
    end

    // Expiry decode on the last allowed waiting cycle.
    always_comb expire = waiting && (wait_cnt == TW'(LIMIT - 1));

    AST_WAIT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (wait_cnt == '0)); // R8
endmodule

// File: rtl/dma_seq.sv
// Transfer sequencer: waits for peripheral readiness, requests the bus,
// issues one request per unit, releases the bus after each burst and
// reports normal or error completion.
// Assumes bus_gnt stays high while bus_req is held.
module dma_seq
    import dma_pkg::*;
#(
    parameter int BURST_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               cnt_zero,
    input  logic               cnt_last,
    input  logic [BURST_W-1:0] blen_m1,
    input  logic               dev_ready,
    input  logic               bus_gnt,
    input  logic               dev_ack,
    input  logic               expire,
    output logic               busy,
    output logic               bus_req,
    output logic               xfer_req,
    output logic               step,
    output logic               fin_ok,
    output logic               fin_err
);
    dma_state_e         state, state_nx;
    logic [BURST_W-1:0] burst_cnt;
    logic               burst_end;

    // Output and event decode from the current state.
    always_comb begin
        busy      = (state != ST_IDLE);
        bus_req   = (state == ST_REQ) || (state == ST_XFER);
        xfer_req  = (state == ST_XFER);
        step      = xfer_req && dev_ack;
        burst_end = (burst_cnt == blen_m1);
        fin_ok    = (state == ST_IDLE && start && cnt_zero) || (step && cnt_last);
        fin_err   = xfer_req && !dev_ack && expire;
    end

    // Next-state selection.
    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE: if (start && !cnt_zero) state_nx = ST_ARM;
            ST_ARM:  if (dev_ready) state_nx = ST_REQ;
            ST_REQ:  if (bus_gnt) state_nx = ST_XFER;
            ST_XFER: begin
                if (step) begin
                    if (cnt_last)       state_nx = ST_IDLE;
                    else if (burst_end) state_nx = ST_REL;
                end else if (expire) begin
                    state_nx = ST_IDLE;
                end
            end
            ST_REL:  state_nx = ST_REQ;
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Units-in-burst counter: restarts on each grant, counts acknowledges.
    always_ff @(posedge clk) begin
        if (!rst_n)
            burst_cnt <= '0;
        else if (state != ST_XFER)
            burst_cnt <= '0;
        else if (step)
            burst_cnt <= burst_cnt + 1'b1;
    end

    AST_BURST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (step && burst_end && !cnt_last) |=> !bus_req); // R6
    AST_BURST_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req |-> (burst_cnt <= blen_m1)); // R6
    AST_NO_REQ_UNREADY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARM && !dev_ready) |=> !bus_req); // R3
endmodule

// File: rtl/dma_flyby_ctrl.sv
// Top of the fly-by DMA controller: register file, sequencer and
// acknowledge watchdog. The peripheral performs the memory access itself;
// this block only drives addresses, requests and bus ownership.
// Assumes a single channel and a request/grant bus arbiter.
module dma_flyby_ctrl
    import dma_pkg::*;
#(
    parameter int RW        = 32,
    parameter int AW        = 32,
    parameter int CW        = 16,
    parameter int BURST_W   = 4,
    parameter int PORT_W    = 4,
    parameter int ACK_LIMIT = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [RW-1:0]     reg_wdata,
    output logic [RW-1:0]     reg_rdata,
    input  logic              dev_ready,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic [AW-1:0]     bus_addr,
    output logic              xfer_req,
    output logic              xfer_dir,
    output logic              xfer_word,
    output logic [PORT_W-1:0] port_sel,
    input  logic              dev_ack,
    output logic              irq
);
    logic               busy, step, fin_ok, fin_err, start;
    logic               cnt_zero, cnt_last, expire, done;
    logic [BURST_W-1:0] blen_m1;

    dma_regs #(.RW(RW), .AW(AW), .CW(CW), .BURST_W(BURST_W), .PORT_W(PORT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy), .step(step),
        .fin_ok(fin_ok), .fin_err(fin_err), .start(start), .cur_addr(bus_addr),
        .cnt_zero(cnt_zero), .cnt_last(cnt_last), .dir(xfer_dir), .word(xfer_word),
        .blen_m1(blen_m1), .port(port_sel), .done(done)
    );

    dma_seq #(.BURST_W(BURST_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .cnt_zero(cnt_zero),
        .cnt_last(cnt_last), .blen_m1(blen_m1), .dev_ready(dev_ready),
        .bus_gnt(bus_gnt), .dev_ack(dev_ack), .expire(expire), .busy(busy),
        .bus_req(bus_req), .xfer_req(xfer_req), .step(step),
        .fin_ok(fin_ok), .fin_err(fin_err)
    );

    dma_ack_watch #(.LIMIT(ACK_LIMIT)) u_watch (
        .clk(clk), .rst_n(rst_n), .waiting(xfer_req && !dev_ack), .expire(expire)
    );

    // Interrupt follows the sticky done flag.
    always_comb irq = done;

    AST_REQ_AFTER_GNT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_req) |-> $past(bus_gnt)); // R4
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && $past(xfer_req && dev_ack)) |->
        (bus_addr == $past(bus_addr) + ($past(xfer_word) ? AW'(4) : AW'(1)))); // R5
    AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (!bus_req && !xfer_req)); // R7
    AST_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !dev_ack) |=> (!xfer_req && irq)); // R8
endmodule

// File: tb/dma_flyby_ctrl_test.sv
module dma_flyby_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        dev_ready = 1'b0;
    logic        bus_req;
    logic        bus_gnt = 1'b0;
    logic [31:0] bus_addr;
    logic        xfer_req, xfer_dir, xfer_word;
    logic [3:0]  port_sel;
    logic        dev_ack = 1'b0;
    logic        irq;

    dma_flyby_ctrl uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dev_ready(dev_ready),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_addr(bus_addr),
        .xfer_req(xfer_req), .xfer_dir(xfer_dir), .xfer_word(xfer_word),
        .port_sel(port_sel), .dev_ack(dev_ack), .irq(irq)
    );

    always #5 clk = ~clk;

    typedef struct packed {
        logic [31:0] addr;
        logic [15:0] cnt;
        logic        word;
        logic        dir;
        logic [3:0]  blen;
        logic [3:0]  port;
        logic [3:0]  delay;
        logic [15:0] units;
        logic [7:0]  bursts;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VEC [NV] = '{
        '{32'h0000_1000, 16'd8,  1'b0, 1'b0, 4'd3,  4'd2,  4'd1, 16'd8, 8'd2},
        '{32'h0000_2000, 16'd16, 1'b1, 1'b1, 4'd0,  4'd5,  4'd0, 16'd4, 8'd4},
        '{32'h0000_3001, 16'd6,  1'b1, 1'b0, 4'd15, 4'd15, 4'd3, 16'd2, 8'd1},
        '{32'hFFFF_FFFE, 16'd5,  1'b0, 1'b1, 4'd1,  4'd7,  4'd2, 16'd5, 8'd3},
        '{32'h0000_0040, 16'd1,  1'b1, 1'b0, 4'd2,  4'd1,  4'd0, 16'd1, 8'd1},
        '{32'h0000_0080, 16'd12, 1'b1, 1'b1, 4'd2,  4'd9,  4'd5, 16'd3, 8'd1}
    };

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    // Peripheral model settings (written by the main process only).
    logic        ack_en = 1'b1;
    int          ack_delay = 0;
    logic [31:0] base_addr = '0;
    int          step_b = 1;
    logic        exp_dir = 1'b0;
    logic        exp_word = 1'b0;
    logic [3:0]  exp_port = '0;
    int          units_base = 0;
    // Peripheral model results (written by the model only).
    int          units = 0;
    int          falls = 0;
    int          dev_err = 0;
    int          wait_c = 0;
    logic        prev_req = 1'b0;

    // Peripheral, arbiter and bus monitor model, driven on falling edges.
    always @(negedge clk) begin
        cycles = cycles + 1;
        if (prev_req && !bus_req) falls = falls + 1;
        prev_req = bus_req;
        bus_gnt = bus_req;
        if (dev_ack) begin
            dev_ack = 1'b0;
            wait_c = 0;
        end else if (xfer_req && ack_en) begin
            if (wait_c >= ack_delay) begin
                if (bus_addr !== base_addr + 32'((units - units_base) * step_b) ||
                    xfer_dir !== exp_dir || xfer_word !== exp_word || port_sel !== exp_port)
                    dev_err = dev_err + 1;
                dev_ack = 1'b1;
                units = units + 1;
            end else begin
                wait_c = wait_c + 1;
            end
        end
        if (cycles > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: run hung, got %0d cycles expected < 150000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] data);
        reg_sel = sel;
        reg_wdata = data;
        reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [31:0] data);
        reg_sel = sel;
        #1;
        data = reg_rdata;
    endtask

    function automatic logic [31:0] mk_ctrl(input logic go, input logic dir, input logic word,
                                            input logic [3:0] blen, input logic [3:0] port);
        return {20'd0, port, blen, 1'b0, word, dir, go};
    endfunction

    task automatic wait_irq(input int limit);
        for (int i = 0; i < limit && !irq; i++) @(negedge clk);
        @(negedge clk);
    endtask

    logic [31:0] rv;
    int          f0, n;

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 bus_req", {31'd0, bus_req}, 32'd0);
        chk("R1 xfer_req", {31'd0, xfer_req}, 32'd0);
        chk("R1 irq", {31'd0, irq}, 32'd0);
        for (int s = 0; s < 4; s++) begin
            rd(2'(s), rv);
            chk("R1 register", rv, 32'd0);
        end
        rst_n = 1'b1;
        @(negedge clk);
        dev_ready = 1'b1;

        // Table walk: R5, R6, R7, R11, R2 readback, R9 clear.
        for (int v = 0; v < NV; v++) begin
            ack_en = 1'b1;
            ack_delay = int'(VEC[v].delay);
            base_addr = VEC[v].addr;
            step_b = VEC[v].word ? 4 : 1;
            exp_dir = VEC[v].dir;
            exp_word = VEC[v].word;
            exp_port = VEC[v].port;
            units_base = units;
            f0 = falls;
            n = dev_err;
            wr(2'd0, VEC[v].addr);
            wr(2'd1, {16'd0, VEC[v].cnt});
            wr(2'd2, mk_ctrl(1'b1, VEC[v].dir, VEC[v].word, VEC[v].blen, VEC[v].port));
            wait_irq(3000);
            chk("R5 unit count", 32'(units - units_base), {16'd0, VEC[v].units});
            chk("R5/R11 per-unit addr, dir, word, port", 32'(dev_err - n), 32'd0);
            chk("R6 bus releases", 32'(falls - f0), {24'd0, VEC[v].bursts});
            chk("R7 irq", {31'd0, irq}, 32'd1);
            rd(2'd3, rv);
            chk("R7 status done, not busy", rv, 32'h2);
            rd(2'd0, rv);
            chk("R2 final address", rv, VEC[v].addr + 32'(int'(VEC[v].units) * step_b));
            rd(2'd1, rv);
            chk("R5 count exhausted", rv, 32'd0);
            wr(2'd3, 32'h2);
            chk("R9 irq cleared", {31'd0, irq}, 32'd0);
        end

        // R3 / R10 / R2: arm without readiness, ignored writes, live readback.
        dev_ready = 1'b0;
        ack_delay = 5;
        base_addr = 32'h500;
        step_b = 1;
        exp_dir = 1'b0;
        exp_word = 1'b0;
        exp_port = 4'd0;
        units_base = units;
        n = dev_err;
        wr(2'd0, 32'h500);
        wr(2'd1, 32'd8);
        wr(2'd2, mk_ctrl(1'b1, 1'b0, 1'b0, 4'd7, 4'd0));
        repeat (10) @(negedge clk);
        chk("R3 no bus request while unready", {31'd0, bus_req}, 32'd0);
        rd(2'd3, rv);
        chk("R3 busy after start", rv, 32'h1);
        wr(2'd0, 32'h999);
        wr(2'd1, 32'd3);
        wr(2'd2, 32'h0000_0FF7);
        rd(2'd0, rv);
        chk("R10 address write ignored", rv, 32'h500);
        rd(2'd1, rv);
        chk("R10 count write ignored", rv, 32'd8);
        rd(2'd2, rv);
        chk("R10 control write ignored", rv, 32'h70);
        dev_ready = 1'b1;
        while (units - units_base < 2) @(negedge clk);
        @(negedge clk);
        rd(2'd1, rv);
        chk("R2 live count", rv, 32'd6);
        rd(2'd0, rv);
        chk("R2 live address", rv, 32'h502);
        wait_irq(3000);
        chk("R5 unready case units", 32'(units - units_base), 32'd8);
        chk("R5 unready case addresses", 32'(dev_err - n), 32'd0);
        wr(2'd3, 32'h2);

        // R7: zero count completes at once with no bus request.
        f0 = falls;
        wr(2'd1, 32'd0);
        wr(2'd2, mk_ctrl(1'b1, 1'b0, 1'b0, 4'd0, 4'd0));
        chk("R7 zero count irq", {31'd0, irq}, 32'd1);
        chk("R7 zero count no bus_req", {31'd0, bus_req}, 32'd0);
        repeat (3) @(negedge clk);
        chk("R7 zero count no release", 32'(falls - f0), 32'd0);
        wr(2'd3, 32'h2);

        // R8: acknowledge never arrives.
        ack_en = 1'b0;
        wr(2'd0, 32'h7000);
        wr(2'd1, 32'd4);
        wr(2'd2, mk_ctrl(1'b1, 1'b0, 1'b0, 4'd3, 4'd0));
        for (int i = 0; i < 50 && !xfer_req; i++) @(negedge clk);
        n = 0;
        while (!irq && n < 400) begin
            @(negedge clk);
            n = n + 1;
        end
        chk("R8 abort after 256 waiting cycles", 32'(n), 32'd256);
        chk("R8 request dropped", {30'd0, bus_req, xfer_req}, 32'd0);
        rd(2'd3, rv);
        chk("R8 status error and done", rv, 32'h6);
        wr(2'd3, 32'h2);
        rd(2'd3, rv);
        chk("R9 error cleared", rv, 32'h0);
        chk("R9 irq low", {31'd0, irq}, 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule